// File: doc/BRIEF.md
# I2C Master Byte Controller

This block sequences an I2C master transfer one byte at a time under software control. Software writes a control word made of an enable bit, a start request, a stop request, an acknowledge-enable bit and a write-1-to-clear bit for the interrupt flag. It also writes a one-byte data register. From these writes the block emits transaction events: a start condition, a stop condition, a slave address, a write byte or a read byte. A bus agent downstream carries out each event and answers with the slave's acknowledge and, for a read, the received byte.

Completion is reported through an 8-bit status code that uses the conventional two-wire master values. The code is posted a fixed number of time units after the event is taken. When it is posted, the interrupt flag is raised. Bus-level bit timing, arbitration and slave operation are not part of this block.

The event port is a valid/ready stream. An event stays on the port, unchanged, until `ev_ready` is seen high at a clock edge. The one exception is a disable write, which withdraws the event. The slave's answer (`sl_ack`, `sl_rdata`) is sampled only in the cycle where the event is handed over; an answer given in any other cycle is never seen, so a missing acknowledge counts as NACK. The status delay starts counting from that handover cycle. Control writes and data writes are plain single-cycle strobes with no back-pressure.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the status is 0xF8, the data register is 0xFF, the interrupt flag, all control bits and `ev_valid` are 0.
- R2: A control write that takes the start bit from 0 to 1 while no transfer is open emits event kind 0 (start). STAT_SHORT×UNIT_CYC cycles after the handover, the status becomes 0x08 and the interrupt flag is set.
- R3: The same start request while a transfer is already open posts 0x10 (repeated start). After a stop has been handed over, a new start posts 0x08 again.
- R4: A control write with the clear bit at 1, start and stop bits at 0, the interrupt flag set and a transfer open, as the first byte after a start, emits event kind 2 carrying the data register. Bit 0 of that byte at 1 selects read. The status posted STAT_LONG×UNIT_CYC cycles after the handover is 0x18/0x20 for a write address and 0x40/0x48 for a read address, ACK/NACK per `sl_ack` in the handover cycle.
- R5: In a write transfer, a later such trigger emits event kind 3 carrying the data register, but only if the data register was written since the previous byte event. The status is 0x28 on slave ACK and 0x30 on NACK.
- R6: In a read transfer, a trigger emits event kind 4 with `ev_ack` equal to the acknowledge-enable bit written with it. It needs the read latch, which a read address or a `dat_rd` pulse sets and each read byte consumes. The data register takes `sl_rdata` at the handover, and the status is 0x50 if `ev_ack` is 1, else 0x58.
- R7: A trigger whose write or read latch is not ready emits no event and leaves the status unchanged; only the interrupt flag clears.
- R8: A stop request (stop bit 0 to 1) in an open transfer emits event kind 1 carrying the address byte. Its handover closes the transfer and changes neither the status nor the interrupt flag. With no transfer open, a stop request emits nothing.
- R9: A control write with the enable bit at 0 sets the status to 0xF8 and the data register to 0xFF, clears all control bits and the interrupt flag, withdraws any event and cancels any pending status.
- R10: A presented event holds `ev_valid`, kind, byte and `ev_ack` stable until `ev_ready` is high; the status delay starts only at that handover.
- R11: Start, stop and byte requests made while an event is presented or a status delay runs are dropped; the control bits are still stored.
- R12: Writing the control word with the clear bit at 0 leaves the interrupt flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_en | input | 1 | Enable bit of the control word |
| cfg_start | input | 1 | Start request bit |
| cfg_stop | input | 1 | Stop request bit |
| cfg_acken | input | 1 | Master acknowledge enable for read bytes |
| cfg_irqclr | input | 1 | Write 1 to clear the interrupt flag / trigger a byte |
| dat_wr | input | 1 | Data register write strobe |
| dat_wdata | input | 8 | Data register write value |
| dat_rd | input | 1 | Data register read pulse (arms the read latch) |
| en_q | output | 1 | Stored enable bit |
| start_q | output | 1 | Stored start bit |
| stop_q | output | 1 | Stored stop bit |
| acken_q | output | 1 | Stored acknowledge-enable bit |
| irq_q | output | 1 | Interrupt flag |
| dat_q | output | 8 | Data register |
| stat_q | output | 8 | Status code |
| ev_valid | output | 1 | Event presented |
| ev_ready | input | 1 | Event accepted by the bus agent |
| ev_kind | output | 3 | 0 start, 1 stop, 2 address, 3 write byte, 4 read byte |
| ev_data | output | 8 | Address or write byte (stop and read carry the address; start carries 0) |
| ev_ack | output | 1 | Master acknowledge for a read byte |
| sl_ack | input | 1 | Slave acknowledge, sampled in the handover cycle |
| sl_rdata | input | 8 | Received byte, sampled at a read-byte handover |

## Verification
The main flow is driven with a write address and a read address, with the slave acknowledging and refusing. This separates the four address codes and shows that bit 0 of the address byte, not the transfer history, picks the code family. Write bytes are tried with and without a preceding data write, and read bytes with and without a prior read pulse, which separates the latch-ready path from the silent drop. Holding `ev_ready` low while a start is presented shows that the status delay runs from the handover and not from the request. A second start inside an open transfer, and a first start after a stop, tell repeated start from fresh start. Stop requests inside and outside a transfer, a request made during a delay, and a disable with an event still presented cover the paths that clear or drop work.

// File: rtl/i2cbm_pkg.sv
package i2cbm_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    EV_START = 3'd0,
    EV_STOP  = 3'd1,
    EV_ADDR  = 3'd2,
    EV_WRITE = 3'd3,
    EV_READ  = 3'd4
  } ev_kind_e;

  typedef struct packed {
    ev_kind_e          kind;
    logic [BYTE_W-1:0] data;
    logic              ack;
  } ev_t;

  localparam logic [BYTE_W-1:0] ST_START   = 8'h08;
  localparam logic [BYTE_W-1:0] ST_RESTART = 8'h10;
  localparam logic [BYTE_W-1:0] ST_WA_ACK  = 8'h18;
  localparam logic [BYTE_W-1:0] ST_WA_NACK = 8'h20;
  localparam logic [BYTE_W-1:0] ST_WD_ACK  = 8'h28;
  localparam logic [BYTE_W-1:0] ST_WD_NACK = 8'h30;
  localparam logic [BYTE_W-1:0] ST_RA_ACK  = 8'h40;
  localparam logic [BYTE_W-1:0] ST_RA_NACK = 8'h48;
  localparam logic [BYTE_W-1:0] ST_RD_ACK  = 8'h50;
  localparam logic [BYTE_W-1:0] ST_RD_NACK = 8'h58;
  localparam logic [BYTE_W-1:0] ST_IDLE    = 8'hF8;
  localparam logic [BYTE_W-1:0] DAT_CLEAR  = 8'hFF;
endpackage

// File: rtl/i2cbm_delay.sv
module i2cbm_delay
  import i2cbm_pkg::*;
#(
  parameter int UNIT_CYC   = 4,
  parameter int STAT_SHORT = 3,
  parameter int STAT_LONG  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kill,
  input  logic              load,
  input  logic              load_long,
  input  logic [BYTE_W-1:0] load_code,
  output logic              busy,
  output logic              fire,
  output logic [BYTE_W-1:0] fire_code
);
  localparam int SHORT_CYC = STAT_SHORT * UNIT_CYC;
  localparam int LONG_CYC  = STAT_LONG * UNIT_CYC;
  localparam int CW        = $clog2(LONG_CYC + 1);

  logic [CW-1:0]     cnt_q;
  logic [BYTE_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      code_q <= '0;
    end else if (kill) begin
      cnt_q  <= '0;
    end else if (load) begin
      cnt_q  <= load_long ? CW'(LONG_CYC) : CW'(SHORT_CYC);
      code_q <= load_code;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy      = (cnt_q != '0);
  assign fire      = (cnt_q == CW'(1));
  assign fire_code = code_q;
endmodule

// File: rtl/i2cbm_evout.sv
module i2cbm_evout
  import i2cbm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic push,
  input  ev_t  push_ev,
  input  logic ready,
  output logic valid,
  output ev_t  ev_q,
  output logic acc
);
  assign acc = valid & ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      ev_q  <= '0;
    end else if (kill) begin
      valid <= 1'b0;
    end else if (push) begin
      valid <= 1'b1;
      ev_q  <= push_ev;
    end else if (acc) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cbm_seq.sv
module i2cbm_seq
  import i2cbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_en,
  input  logic              cfg_start,
  input  logic              cfg_stop,
  input  logic              cfg_acken,
  input  logic              cfg_irqclr,
  input  logic              dat_wr,
  input  logic [BYTE_W-1:0] dat_wdata,
  input  logic              dat_rd,
  input  logic              ev_valid,
  input  logic              acc,
  input  ev_t               acc_ev,
  input  logic              sl_ack,
  input  logic [BYTE_W-1:0] sl_rdata,
  input  logic              dly_busy,
  input  logic              fire,
  input  logic [BYTE_W-1:0] fire_code,
  output logic              kill,
  output logic              push,
  output ev_t               push_ev,
  output logic              load,
  output logic              load_long,
  output logic [BYTE_W-1:0] load_code,
  output logic              en_q,
  output logic              start_q,
  output logic              stop_q,
  output logic              acken_q,
  output logic              irq_q,
  output logic [BYTE_W-1:0] dat_q,
  output logic [BYTE_W-1:0] stat_q
);
  logic              open_q, rep_q, addr_done_q, rd_q, wlatch_q, rlatch_q;
  logic [BYTE_W-1:0] peer_q;

  logic busy, go, rise_sto, rise_sta, trig;
  logic act_stop_ev, act_stop_clr, act_start, act_addr, act_rd, act_wr;
  logic byte_go;

  assign kill     = cfg_wr & ~cfg_en;
  assign busy     = ev_valid | dly_busy;
  assign go       = cfg_wr & cfg_en & ~busy;
  assign rise_sto = cfg_stop & ~stop_q;
  assign rise_sta = cfg_start & ~start_q;
  assign trig     = cfg_irqclr & irq_q & ~cfg_start & ~cfg_stop & open_q;
  assign byte_go  = go & ~rise_sto & ~rise_sta & trig;

  assign act_stop_ev  = go & rise_sto & open_q;
  assign act_stop_clr = go & rise_sto & ~open_q;
  assign act_start    = go & ~rise_sto & rise_sta;
  assign act_addr     = byte_go & ~addr_done_q;
  assign act_rd       = byte_go & addr_done_q & rd_q & rlatch_q;
  assign act_wr       = byte_go & addr_done_q & ~rd_q & wlatch_q;
  assign push         = act_stop_ev | act_start | act_addr | act_rd | act_wr;

  always_comb begin
    push_ev = '{kind: EV_START, data: '0, ack: 1'b0};
    if (act_stop_ev) push_ev = '{kind: EV_STOP,  data: peer_q, ack: 1'b0};
    if (act_addr)    push_ev = '{kind: EV_ADDR,  data: dat_q,  ack: 1'b0};
    if (act_wr)      push_ev = '{kind: EV_WRITE, data: dat_q,  ack: 1'b0};
    if (act_rd)      push_ev = '{kind: EV_READ,  data: peer_q, ack: cfg_acken};
  end

  // status code chosen at handover, from the sampled slave answer
  assign load      = acc & (acc_ev.kind != EV_STOP) & ~kill;
  assign load_long = (acc_ev.kind != EV_START);
  always_comb begin
    case (acc_ev.kind)
      EV_START: load_code = rep_q ? ST_RESTART : ST_START;
      EV_ADDR:  load_code = acc_ev.data[0] ? (sl_ack ? ST_RA_ACK : ST_RA_NACK)
                                           : (sl_ack ? ST_WA_ACK : ST_WA_NACK);
      EV_WRITE: load_code = sl_ack ? ST_WD_ACK : ST_WD_NACK;
      EV_READ:  load_code = acc_ev.ack ? ST_RD_ACK : ST_RD_NACK;
      default:  load_code = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || kill) begin
      en_q <= 1'b0; start_q <= 1'b0; stop_q <= 1'b0; acken_q <= 1'b0;
      irq_q <= 1'b0; dat_q <= DAT_CLEAR; stat_q <= ST_IDLE;
      open_q <= 1'b0; rep_q <= 1'b0; addr_done_q <= 1'b0; rd_q <= 1'b0;
      wlatch_q <= 1'b0; rlatch_q <= 1'b0; peer_q <= '0;
    end else begin
      if ((acc && acc_ev.kind == EV_STOP) || act_stop_clr) begin
        open_q <= 1'b0; addr_done_q <= 1'b0; rd_q <= 1'b0;
        wlatch_q <= 1'b0; rlatch_q <= 1'b0; peer_q <= '0;
      end
      if (dat_wr) begin
        dat_q <= dat_wdata;
        if (en_q) wlatch_q <= 1'b1;
      end
      if (acc && acc_ev.kind == EV_READ) dat_q <= sl_rdata;
      if (dat_rd && en_q) rlatch_q <= 1'b1;
      if (cfg_wr) begin
        en_q    <= 1'b1;
        start_q <= cfg_start;
        stop_q  <= cfg_stop;
        acken_q <= cfg_acken;
        if (cfg_irqclr) irq_q <= 1'b0;
      end
      if (act_start) begin
        open_q <= 1'b1; rep_q <= open_q; addr_done_q <= 1'b0; rd_q <= 1'b0;
        wlatch_q <= 1'b0; rlatch_q <= 1'b0; peer_q <= '0;
      end
      if (act_addr) begin
        peer_q <= dat_q; addr_done_q <= 1'b1; rd_q <= dat_q[0];
        rlatch_q <= dat_q[0]; wlatch_q <= 1'b0;
      end
      if (act_rd) rlatch_q <= 1'b0;
      if (act_wr) wlatch_q <= 1'b0;
      if (fire) begin
        stat_q <= fire_code;
        irq_q  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cbm_pkg::*;
#(
  parameter int UNIT_CYC   = 4,
  parameter int STAT_SHORT = 3,
  parameter int STAT_LONG  = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        cfg_en,
  input  logic        cfg_start,
  input  logic        cfg_stop,
  input  logic        cfg_acken,
  input  logic        cfg_irqclr,
  input  logic        dat_wr,
  input  logic [7:0]  dat_wdata,
  input  logic        dat_rd,
  output logic        en_q,
  output logic        start_q,
  output logic        stop_q,
  output logic        acken_q,
  output logic        irq_q,
  output logic [7:0]  dat_q,
  output logic [7:0]  stat_q,
  output logic        ev_valid,
  input  logic        ev_ready,
  output logic [2:0]  ev_kind,
  output logic [7:0]  ev_data,
  output logic        ev_ack,
  input  logic        sl_ack,
  input  logic [7:0]  sl_rdata
);
  logic              kill, push, acc, load, load_long, dly_busy, fire;
  logic [BYTE_W-1:0] load_code, fire_code;
  ev_t               push_ev, ev_q;

  i2cbm_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_start(cfg_start), .cfg_stop(cfg_stop),
    .cfg_acken(cfg_acken), .cfg_irqclr(cfg_irqclr),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rd(dat_rd),
    .ev_valid(ev_valid), .acc(acc), .acc_ev(ev_q),
    .sl_ack(sl_ack), .sl_rdata(sl_rdata),
    .dly_busy(dly_busy), .fire(fire), .fire_code(fire_code),
    .kill(kill), .push(push), .push_ev(push_ev),
    .load(load), .load_long(load_long), .load_code(load_code),
    .en_q(en_q), .start_q(start_q), .stop_q(stop_q), .acken_q(acken_q),
    .irq_q(irq_q), .dat_q(dat_q), .stat_q(stat_q)
  );

  i2cbm_evout u_evout (
    .clk(clk), .rst_n(rst_n), .kill(kill), .push(push), .push_ev(push_ev),
    .ready(ev_ready), .valid(ev_valid), .ev_q(ev_q), .acc(acc)
  );

  i2cbm_delay #(.UNIT_CYC(UNIT_CYC), .STAT_SHORT(STAT_SHORT), .STAT_LONG(STAT_LONG)) u_delay (
    .clk(clk), .rst_n(rst_n), .kill(kill), .load(load), .load_long(load_long),
    .load_code(load_code), .busy(dly_busy), .fire(fire), .fire_code(fire_code)
  );

  assign ev_kind = ev_q.kind;
  assign ev_data = ev_q.data;
  assign ev_ack  = ev_q.ack;
endmodule

// File: rtl/i2cbm_checker.sv
module i2cbm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic       cfg_en,
  input logic       en_q,
  input logic       start_q,
  input logic       stop_q,
  input logic       acken_q,
  input logic       irq_q,
  input logic [7:0] dat_q,
  input logic [7:0] stat_q,
  input logic       ev_valid,
  input logic       ev_ready,
  input logic [2:0] ev_kind,
  input logic [7:0] ev_data,
  input logic       ev_ack
);
  a_r10_event_held: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready && !(cfg_wr && !cfg_en) |=>
      ev_valid && $stable(ev_kind) && $stable(ev_data) && $stable(ev_ack));

  a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && !cfg_en |=>
      stat_q == 8'hF8 && dat_q == 8'hFF && !irq_q && !en_q && !start_q &&
      !stop_q && !acken_q && !ev_valid);

  a_r2_flag_after_handover: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> !ev_valid);

  a_r12_status_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && !$stable(stat_q) |-> irq_q);

  a_r8_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready && ev_kind == 3'd1 && !cfg_wr |=>
      $stable(stat_q) && $stable(irq_q));
endmodule

bind i2c_byte_master i2cbm_checker u_chk (.*);

// File: tb/i2c_byte_master_tb.sv
module i2c_byte_master_tb;
  localparam int U = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 0, cfg_en = 0, cfg_start = 0, cfg_stop = 0, cfg_acken = 0, cfg_irqclr = 0;
  logic dat_wr = 0, dat_rd = 0, ev_ready = 1, sl_ack = 0;
  logic [7:0] dat_wdata = 0, sl_rdata = 0;
  logic en_q, start_q, stop_q, acken_q, irq_q, ev_valid, ev_ack;
  logic [7:0] dat_q, stat_q, ev_data;
  logic [2:0] ev_kind;
  int errors = 0, checks = 0;
  logic [2:0] q_kind[$];
  logic [7:0] q_data[$];
  logic       q_ack[$];

  always #10 clk = ~clk;

  i2c_byte_master #(.UNIT_CYC(U)) u_dut (.*);

  // behavioural reference model
  logic m_en, m_sta, m_sto, m_ak, m_irq, m_st, m_rep, m_ad, m_rd, m_wl, m_rl, m_v, m_eack;
  logic [7:0] m_dat, m_stat, m_peer, m_data, m_code;
  int m_kind, m_cnt;

  task automatic m_reset();
    m_en = 0; m_sta = 0; m_sto = 0; m_ak = 0; m_irq = 0; m_dat = 8'hFF; m_stat = 8'hF8;
    m_st = 0; m_rep = 0; m_ad = 0; m_rd = 0; m_wl = 0; m_rl = 0; m_peer = 0;
    m_v = 0; m_cnt = 0;
  endtask

  task automatic m_push(int k, logic [7:0] d, logic a);
    m_v = 1; m_kind = k; m_data = d; m_eack = a;
  endtask

  initial begin m_kind = 0; m_data = 0; m_eack = 0; m_code = 0; m_reset(); end

  always @(posedge clk) begin
    if (!rst_n || (cfg_wr && !cfg_en)) m_reset();
    else begin
      automatic logic acc = m_v && ev_ready;
      automatic logic busy = m_v || (m_cnt > 0);
      automatic logic fire = (m_cnt == 1);
      automatic logic o_sta = m_sta, o_sto = m_sto, o_irq = m_irq, o_st = m_st;
      automatic logic o_ad = m_ad, o_rd = m_rd, o_wl = m_wl, o_rl = m_rl;
      automatic logic [7:0] o_dat = m_dat, o_peer = m_peer;
      automatic logic do_clr = 0;
      if (acc) begin
        m_v = 0;
        case (m_kind)
          0: begin m_cnt = 3*U; m_code = m_rep ? 8'h10 : 8'h08; end
          1: do_clr = 1;
          2: begin m_cnt = 9*U;
                   m_code = m_data[0] ? (sl_ack ? 8'h40 : 8'h48) : (sl_ack ? 8'h18 : 8'h20); end
          3: begin m_cnt = 9*U; m_code = sl_ack ? 8'h28 : 8'h30; end
          default: begin m_cnt = 9*U; m_code = m_eack ? 8'h50 : 8'h58; end
        endcase
      end else if (m_cnt > 0) m_cnt--;
      if (do_clr) begin m_st = 0; m_ad = 0; m_rd = 0; m_wl = 0; m_rl = 0; m_peer = 0; end
      if (dat_wr) begin m_dat = dat_wdata; if (m_en) m_wl = 1; end
      if (acc && m_kind == 4) m_dat = sl_rdata;
      if (dat_rd && m_en) m_rl = 1;
      if (cfg_wr) begin
        m_en = 1; m_sta = cfg_start; m_sto = cfg_stop; m_ak = cfg_acken;
        if (cfg_irqclr) m_irq = 0;
        if (!busy) begin
          if (cfg_stop && !o_sto) begin
            if (o_st) m_push(1, o_peer, 0);
            else begin m_st = 0; m_ad = 0; m_rd = 0; m_wl = 0; m_rl = 0; m_peer = 0; end
          end else if (cfg_start && !o_sta) begin
            m_push(0, 0, 0); m_rep = o_st; m_st = 1; m_ad = 0; m_rd = 0;
            m_wl = 0; m_rl = 0; m_peer = 0;
          end else if (cfg_irqclr && o_irq && !cfg_start && !cfg_stop && o_st) begin
            if (!o_ad) begin
              m_push(2, o_dat, 0); m_peer = o_dat; m_ad = 1; m_rd = o_dat[0];
              m_rl = o_dat[0]; m_wl = 0;
            end else if (o_rd && o_rl) begin m_push(4, o_peer, cfg_acken); m_rl = 0; end
            else if (!o_rd && o_wl) begin m_push(3, o_dat, 0); m_wl = 0; end
          end
        end
      end
      if (fire) begin m_stat = m_code; m_irq = 1; end
    end
  end

  // handover monitor
  always @(posedge clk)
    if (rst_n && ev_valid && ev_ready) begin
      q_kind.push_back(ev_kind); q_data.push_back(ev_data); q_ack.push_back(ev_ack);
    end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk)
    if (rst_n) begin
      chk("model ctl/irq/dat/stat/valid",
          {en_q, start_q, stop_q, acken_q, irq_q, dat_q, stat_q, ev_valid},
          {m_en, m_sta, m_sto, m_ak, m_irq, m_dat, m_stat, m_v});
      if (ev_valid) chk("model event", {ev_kind, ev_data, ev_ack}, {m_kind[2:0], m_data, m_eack});
    end

  task automatic ctl(logic en, logic sta, logic sto, logic ak, logic clr);
    @(negedge clk);
    cfg_wr = 1; cfg_en = en; cfg_start = sta; cfg_stop = sto; cfg_acken = ak; cfg_irqclr = clr;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic dwr(logic [7:0] d);
    @(negedge clk); dat_wr = 1; dat_wdata = d; @(negedge clk); dat_wr = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(string tag);
    int n = 0;
    @(negedge clk);
    while (!irq_q && n < 200) begin @(negedge clk); n++; end
    chk({tag, " flag raised"}, irq_q, 1);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n0;
    idle(3); @(negedge clk); rst_n = 1; idle(1);
    chk("R1 status", stat_q, 8'hF8);
    chk("R1 data", dat_q, 8'hFF);
    chk("R1 flag/bits/valid", {irq_q, en_q, start_q, stop_q, acken_q, ev_valid}, 0);

    sl_ack = 1;
    ctl(1, 1, 0, 0, 0); wait_irq("R2");
    chk("R2 start status", stat_q, 8'h08);
    chk("R2 start event", q_kind[q_kind.size()-1], 0);

    dwr(8'hA4); ctl(1, 0, 0, 0, 1); wait_irq("R4");
    chk("R4 write addr ACK", stat_q, 8'h18);
    chk("R4 addr event", {q_kind[q_kind.size()-1], q_data[q_data.size()-1]}, {3'd2, 8'hA4});

    dwr(8'h5C); sl_ack = 0; ctl(1, 0, 0, 0, 1); wait_irq("R5");
    chk("R5 write byte NACK", stat_q, 8'h30);
    chk("R5 write event", {q_kind[q_kind.size()-1], q_data[q_data.size()-1]}, {3'd3, 8'h5C});

    n0 = q_kind.size();
    ctl(1, 0, 0, 0, 1); idle(50);
    chk("R7 no write event without data", q_kind.size(), n0);
    chk("R7 status kept, flag cleared", {stat_q, irq_q}, {8'h30, 1'b0});

    ev_ready = 0; ctl(1, 1, 0, 0, 0); idle(6);
    chk("R10 event held while not ready", ev_valid, 1);
    chk("R10 no status before handover", stat_q, 8'h30);
    ev_ready = 1; wait_irq("R3");
    chk("R3 repeated start", stat_q, 8'h10);

    dwr(8'hA5); ctl(1, 0, 0, 1, 1); wait_irq("R4");
    chk("R4 read addr NACK", stat_q, 8'h48);

    sl_rdata = 8'h3E; ctl(1, 0, 0, 1, 1); wait_irq("R6");
    chk("R6 read ACK status", stat_q, 8'h50);
    chk("R6 read data loaded", dat_q, 8'h3E);
    chk("R6 read event ack", {q_kind[q_kind.size()-1], q_ack[q_ack.size()-1]}, {3'd4, 1'b1});

    @(negedge clk); dat_rd = 1; @(negedge clk); dat_rd = 0;
    sl_rdata = 8'h91; ctl(1, 0, 0, 0, 1); wait_irq("R6");
    chk("R6 read NACK status", stat_q, 8'h58);
    chk("R6 second read data", dat_q, 8'h91);

    n0 = q_kind.size();
    ctl(1, 0, 0, 0, 1); idle(50);
    chk("R7 no read event without latch", q_kind.size(), n0);
    chk("R7 read status kept", stat_q, 8'h58);

    ctl(1, 0, 1, 0, 0); idle(10);
    chk("R8 stop event", {q_kind[q_kind.size()-1], q_data[q_data.size()-1]}, {3'd1, 8'hA5});
    chk("R8 status/flag unchanged", {stat_q, irq_q}, {8'h58, 1'b0});

    ctl(1, 0, 0, 0, 0); ctl(1, 1, 0, 0, 0);
    n0 = q_kind.size();
    ctl(1, 1, 1, 0, 0);
    wait_irq("R11");
    chk("R11 stop during delay dropped", q_kind.size(), n0 + 1);
    chk("R3 fresh start after stop", stat_q, 8'h08);

    ctl(1, 0, 0, 0, 0);
    chk("R12 flag kept without clear bit", irq_q, 1);
    dwr(8'h22); ev_ready = 0; ctl(1, 0, 0, 1, 1); idle(2);
    chk("R9 address presented", ev_valid, 1);
    ctl(0, 1, 1, 1, 0);
    chk("R9 event withdrawn", ev_valid, 0);
    chk("R9 status/data", {stat_q, dat_q}, {8'hF8, 8'hFF});
    chk("R9 bits cleared", {irq_q, en_q, start_q, stop_q, acken_q}, 0);
    n0 = q_kind.size();
    ev_ready = 1; idle(40);
    chk("R9 nothing handed over", q_kind.size(), n0);

    ctl(1, 0, 1, 0, 0); idle(10);
    chk("R8 stop outside transfer silent", q_kind.size(), n0);

    idle(5);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule